// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block is the controller-side receiver for the inbound direction of a fixed-rate, time-division serial audio link. It runs from the link's bit clock and samples the codec's serial data line on every falling edge, when the line is stable. It uses the frame strobe that the controller generates itself to find where each frame starts. Each frame is 256 bits long. The first 16 bits form a tag field. Twelve data slots of 20 bits each follow it.

The tag field carries the flags. One flag says whether the frame as a whole is meaningful. Twelve more flags say which data slots carry data. The receiver keeps the 16 most significant bits of each slot and drops the last four. When the final bit of a frame arrives, the flags and all twelve slot words are published together in one clock edge, and a one-cycle completion strobe is raised. A slot whose flag is clear is published as zero. Downstream logic reads the whole frame at the strobe and never sees a mix of two frames.

Top module: `serlink_frame_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first complete frame, `frame_valid`, `slot_valid`, `slot_data` and `frame_done` are all zero.
- R2: Data is sampled on falling edges of `bit_clk`. The first sample taken while `sync` is high, after a sample that saw `sync` low, is frame bit 0. Every later falling edge advances the bit position by one.
- R3: `frame_valid` reports frame bit 0 (tag bit 15, the first bit on the line) of the last complete frame.
- R4: Frame bits 1 to 12 (tag bits 14 down to 3) are the flags for slots 1 to 12, reported on `slot_valid[0]` to `slot_valid[11]` in that order. Frame bits 13 to 15 (tag bits 2 to 0) have no effect on any output.
- R5: Slot k (k = 1..12) occupies frame bits 16+20(k-1) through 35+20(k-1), most significant bit first. Its first 16 bits appear on `slot_data[16k-1:16k-16]`, with the first bit at the top. The remaining 4 bits have no effect on any output.
- R6: A slot whose flag is clear in a complete frame is reported as 16'h0000, whatever bits it carried.
- R7: On the falling edge that samples frame bit 255, all outputs update together and `frame_done` is high for exactly one bit-clock period. There is exactly one such pulse per complete frame.
- R8: Between `frame_done` pulses, `frame_valid`, `slot_valid` and `slot_data` hold their values, whatever arrives on `sdata_in`.
- R9: A new rise of `sync` before frame bit 255 restarts the frame at bit 0. The partial frame produces no pulse and no output change.
- R10: After frame bit 255 the receiver ignores `sdata_in` until the next rise of `sync`. Without such a rise, no further frame is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock; inputs are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Locally generated frame strobe; its rise marks frame bit 0 |
| sdata_in | input | 1 | Serial data from the codec, changing on rising edges |
| frame_valid | output | 1 | Whole-frame valid flag of the last complete frame |
| slot_valid | output | 12 | Per-slot valid flags, bit 0 for slot 1 |
| slot_data | output | 192 | Upper 16 bits of each slot, slot 1 in bits 15:0 |
| frame_done | output | 1 | One-cycle strobe when a complete frame is published |

## Verification
A frame with every flag set and distinct payloads checks slot placement and bit order. A walking single flag, swept across all twelve slots, checks that each flag maps to the right slot and that zeroing affects only the flagged-off slots. Frames with the whole-frame flag clear, with the three spare tag bits set, and with payload only in the four dropped bits of each slot check that those bits have no effect. A frame restarted part-way by an early strobe, followed by a long stretch of line noise with no strobe, checks that partial and unframed data are never published and that outputs hold between frames.

// File: rtl/serlink_rx_pkg.sv
package serlink_rx_pkg;

  // first frame bit of data slot k (k counted from zero)
  function automatic int slot_base(input int tag_w, input int slot_w, input int k);
    return tag_w + k * slot_w;
  endfunction

  // total bits in one frame
  function automatic int frame_bits(input int tag_w, input int slot_w, input int nslot);
    return tag_w + nslot * slot_w;
  endfunction

  // position in the tag word of the flag for slot k (k counted from zero)
  function automatic int flag_pos(input int tag_w, input int k);
    return tag_w - 2 - k;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/serlink_bit_counter.sv
module serlink_bit_counter
  import serlink_rx_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             sync,
  output logic             sample_en,
  output logic             frame_start,
  output logic             last_bit,
  output logic [IDX_W-1:0] cur_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             sync_q;
  logic             active;
  logic [IDX_W-1:0] cnt;

  assign frame_start = sync & ~sync_q;
  assign sample_en   = frame_start | active;
  assign cur_idx     = frame_start ? '0 : cnt;
  assign last_bit    = sample_en && (cur_idx == LAST_IDX);

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= sync;
      if (last_bit) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (frame_start) begin
        active <= 1'b1;
        cnt    <= IDX_W'(1);
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  restart_on_rise_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_start && !last_bit) |=> (active && cnt == IDX_W'(1)));

  // R2
  step_by_one_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (active && !frame_start && cnt != LAST_IDX) |=> (cnt == $past(cnt) + 1'b1));

  // R10
  idle_after_last_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    last_bit |=> !active);

endmodule

// File: rtl/serlink_slot_locator.sv
module serlink_slot_locator
  import serlink_rx_pkg::*;
#(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int NSLOT      = 12,
  parameter int IDX_W      = 8,
  parameter int SLOT_IDX_W = 4,
  parameter int POS_W      = 5
) (
  input  logic [IDX_W-1:0]      idx,
  output logic                  in_tag,
  output logic [SLOT_IDX_W-1:0] slot,
  output logic [POS_W-1:0]      pos
);

  always_comb begin
    in_tag = (int'(idx) < TAG_W);
    slot   = '0;
    pos    = POS_W'(idx);
    for (int k = 0; k < NSLOT; k++) begin
      if (int'(idx) >= slot_base(TAG_W, SLOT_W, k) &&
          int'(idx) <  slot_base(TAG_W, SLOT_W, k) + SLOT_W) begin
        slot = SLOT_IDX_W'(k);
        pos  = POS_W'(int'(idx) - slot_base(TAG_W, SLOT_W, k));
      end
    end
  end

endmodule

// File: rtl/serlink_capture.sv
module serlink_capture #(
  parameter int TAG_W      = 16,
  parameter int NSLOT      = 12,
  parameter int KEEP_W     = 16,
  parameter int SLOT_IDX_W = 4,
  parameter int POS_W      = 5
) (
  input  logic                             bit_clk,
  input  logic                             rst_n,
  input  logic                             sample_en,
  input  logic                             sdata_in,
  input  logic                             in_tag,
  input  logic [SLOT_IDX_W-1:0]            slot,
  input  logic [POS_W-1:0]                 pos,
  output logic [TAG_W-1:0]                 tag_sr,
  output logic [NSLOT-1:0][KEEP_W-1:0]     data_sr
);

  logic             tag_en;
  logic [NSLOT-1:0] keep_en;

  assign tag_en = sample_en & in_tag;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) tag_sr <= '0;
    else if (tag_en) tag_sr <= {tag_sr[TAG_W-2:0], sdata_in};
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign keep_en[k] = sample_en && !in_tag &&
                        (slot == SLOT_IDX_W'(k)) && (int'(pos) < KEEP_W);

    always_ff @(negedge bit_clk or negedge rst_n) begin
      if (!rst_n) data_sr[k] <= '0;
      else if (keep_en[k]) data_sr[k] <= {data_sr[k][KEEP_W-2:0], sdata_in};
    end
  end

  // R5
  one_slot_shifts_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    $onehot0(keep_en));

  // R5
  tag_or_slot_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    tag_en |-> (keep_en == '0));

endmodule

// File: rtl/serlink_publish.sv
module serlink_publish
  import serlink_rx_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int NSLOT  = 12,
  parameter int KEEP_W = 16
) (
  input  logic                         bit_clk,
  input  logic                         rst_n,
  input  logic                         last_bit,
  input  logic [TAG_W-1:0]             tag_sr,
  input  logic [NSLOT-1:0][KEEP_W-1:0] data_sr,
  output logic                         frame_valid,
  output logic [NSLOT-1:0]             slot_valid,
  output logic [NSLOT-1:0][KEEP_W-1:0] slot_data,
  output logic                         frame_done
);

  localparam int SPARE_W = TAG_W - 1 - NSLOT;

  logic [NSLOT-1:0] flags;

  for (genvar k = 0; k < NSLOT; k++) begin : g_flag
    assign flags[k] = tag_sr[flag_pos(TAG_W, k)];
  end

  if (SPARE_W > 0) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^tag_sr[SPARE_W-1:0];
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      slot_valid  <= '0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= last_bit;
      if (last_bit) begin
        frame_valid <= tag_sr[TAG_W-1];
        slot_valid  <= flags;
      end
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_word
    always_ff @(negedge bit_clk or negedge rst_n) begin
      if (!rst_n) slot_data[k] <= '0;
      else if (last_bit) slot_data[k] <= flags[k] ? data_sr[k] : '0;
    end

    // R6
    cleared_slot_zero_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
      !slot_valid[k] |-> (slot_data[k] == '0));
  end

  // R7
  single_pulse_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8
  hold_flags_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> ($stable(slot_valid) && $stable(frame_valid)));

  // R8
  hold_data_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> $stable(slot_data));

endmodule

// File: rtl/serlink_frame_rx.sv
module serlink_frame_rx
  import serlink_rx_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12,
  parameter int KEEP_W = 16
) (
  input  logic                    bit_clk,
  input  logic                    rst_n,
  input  logic                    sync,
  input  logic                    sdata_in,
  output logic                    frame_valid,
  output logic [NSLOT-1:0]        slot_valid,
  output logic [NSLOT*KEEP_W-1:0] slot_data,
  output logic                    frame_done
);

  localparam int FRAME_LEN  = frame_bits(TAG_W, SLOT_W, NSLOT);
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int SLOT_IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int POS_W      = $clog2(max2(TAG_W, SLOT_W));

  logic                         sample_en;
  logic                         frame_start;
  logic                         last_bit;
  logic [IDX_W-1:0]             cur_idx;
  logic                         in_tag;
  logic [SLOT_IDX_W-1:0]        slot;
  logic [POS_W-1:0]             pos;
  logic [TAG_W-1:0]             tag_sr;
  logic [NSLOT-1:0][KEEP_W-1:0] data_sr;
  logic [NSLOT-1:0][KEEP_W-1:0] words;

  serlink_bit_counter #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) i_counter (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .sync        (sync),
    .sample_en   (sample_en),
    .frame_start (frame_start),
    .last_bit    (last_bit),
    .cur_idx     (cur_idx)
  );

  serlink_slot_locator #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT),
    .IDX_W(IDX_W), .SLOT_IDX_W(SLOT_IDX_W), .POS_W(POS_W)
  ) i_locator (
    .idx    (cur_idx),
    .in_tag (in_tag),
    .slot   (slot),
    .pos    (pos)
  );

  serlink_capture #(
    .TAG_W(TAG_W), .NSLOT(NSLOT), .KEEP_W(KEEP_W),
    .SLOT_IDX_W(SLOT_IDX_W), .POS_W(POS_W)
  ) i_capture (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .sdata_in  (sdata_in),
    .in_tag    (in_tag),
    .slot      (slot),
    .pos       (pos),
    .tag_sr    (tag_sr),
    .data_sr   (data_sr)
  );

  serlink_publish #(.TAG_W(TAG_W), .NSLOT(NSLOT), .KEEP_W(KEEP_W)) i_publish (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .last_bit    (last_bit),
    .tag_sr      (tag_sr),
    .data_sr     (data_sr),
    .frame_valid (frame_valid),
    .slot_valid  (slot_valid),
    .slot_data   (words),
    .frame_done  (frame_done)
  );

  assign slot_data = words;

  // R7
  done_after_last_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |-> $past(last_bit));

  // R2
  start_is_bit_zero_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_start |-> (in_tag && sample_en));

endmodule

// File: tb/test_serlink_frame_rx.sv
module test_serlink_frame_rx;

  localparam int PERIOD = 10;
  localparam int NSLOT  = 12;

  logic         bit_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         sync    = 1'b0;
  logic         sdata   = 1'b0;
  logic         frame_valid;
  logic [11:0]  slot_valid;
  logic [191:0] slot_data;
  logic         frame_done;

  int n_cmp = 0;
  int n_bad = 0;
  int pulses = 0;
  int exp_pulses = 0;

  logic [15:0] tagv;
  logic [19:0] pay [NSLOT];
  logic        e_fv;
  logic [11:0] e_sv;
  logic [15:0] e_data [NSLOT];

  serlink_frame_rx i_serlink_frame_rx (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .sync        (sync),
    .sdata_in    (sdata),
    .frame_valid (frame_valid),
    .slot_valid  (slot_valid),
    .slot_data   (slot_data),
    .frame_done  (frame_done)
  );

  always #(PERIOD/2) bit_clk = ~bit_clk;

  always @(posedge bit_clk) if (frame_done === 1'b1) pulses++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line value of frame bit b for the current tagv/pay
  function automatic logic frame_bit(input int b);
    int k, p;
    if (b < 16) return tagv[15-b];
    k = (b - 16) / 20;
    p = (b - 16) % 20;
    return pay[k][19-p];
  endfunction

  task automatic drive(input logic s, input logic d);
    @(posedge bit_clk); #1;
    sync  = s;
    sdata = d;
  endtask

  task automatic send(input int nbits);
    for (int b = 0; b < nbits; b++) drive(b < 16, frame_bit(b));
  endtask

  // expected outputs computed from the frame contents
  task automatic predict();
    e_fv = tagv[15];
    for (int k = 0; k < NSLOT; k++) begin
      e_sv[k]   = tagv[14-k];
      e_data[k] = e_sv[k] ? pay[k][19:4] : 16'h0;
    end
  endtask

  task automatic check_outputs(input string tagmsg);
    chk(frame_valid == e_fv, {"R3 ", tagmsg}, 64'(frame_valid), 64'(e_fv));
    chk(slot_valid == e_sv, {"R4 ", tagmsg}, 64'(slot_valid), 64'(e_sv));
    for (int k = 0; k < NSLOT; k++)
      chk(slot_data[16*k +: 16] == e_data[k],
          $sformatf("R5/R6 %s slot %0d", tagmsg, k + 1),
          64'(slot_data[16*k +: 16]), 64'(e_data[k]));
  endtask

  // full frame, then checks at the next rising edge and one after
  task automatic frame(input string tagmsg);
    send(256);
    predict();
    exp_pulses++;
    @(posedge bit_clk); #1;
    sync = 1'b0; sdata = 1'b0;
    chk(frame_done === 1'b1, {"R7 done ", tagmsg}, 64'(frame_done), 64'd1);
    chk(pulses == exp_pulses, {"R7 count ", tagmsg}, 64'(pulses), 64'(exp_pulses));
    check_outputs(tagmsg);
    @(posedge bit_clk); #1;
    chk(frame_done === 1'b0, {"R7 drop ", tagmsg}, 64'(frame_done), 64'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge bit_clk);
    #1;
    // R1 during reset
    chk(frame_done === 1'b0 && frame_valid === 1'b0, "R1 in reset",
        64'({frame_done, frame_valid}), 64'd0);
    chk(slot_valid === 12'h0 && slot_data === '0, "R1 in reset data",
        64'(slot_valid), 64'd0);
    rst_n = 1'b1;
    repeat (20) drive(1'b0, 1'b1);
    // R1 after release, no frame yet
    chk(frame_done === 1'b0 && slot_data === '0 && slot_valid === 12'h0,
        "R1 after release", 64'(slot_valid), 64'd0);

    // all flags set, distinct payloads (spare tag bits clear)
    tagv = 16'hFFF8;
    for (int k = 0; k < NSLOT; k++) pay[k] = 20'((k + 1) * 20'h1111) ^ 20'hA5A5F;
    frame("R2 all-valid");

    // walking single slot flag, R4 and R6
    for (int w = 0; w < NSLOT; w++) begin
      tagv = 16'h8000 | (16'h1 << (14 - w));
      for (int k = 0; k < NSLOT; k++) pay[k] = {16'((k + 1) * 16'h1357 + w), 4'hC};
      frame($sformatf("walk %0d", w));
    end

    // frame flag clear, spare tag bits set (R3, R4)
    tagv = 16'h5557;
    for (int k = 0; k < NSLOT; k++) pay[k] = 20'($urandom);
    frame("R4 spare-bits");

    // payload only in the dropped four bits (R5)
    tagv = 16'hFFF8;
    for (int k = 0; k < NSLOT; k++) pay[k] = 20'h0000F;
    frame("R5 low-nibble");

    // early restart: partial frame then full frame (R9)
    tagv = 16'h9248;
    for (int k = 0; k < NSLOT; k++) pay[k] = 20'hFFFFF;
    send(100);
    chk(pulses == exp_pulses, "R9 no pulse for partial", 64'(pulses), 64'(exp_pulses));
    // outputs still from the low-nibble frame
    check_outputs("R9 partial");
    tagv = 16'hEDB0;
    for (int k = 0; k < NSLOT; k++) pay[k] = 20'($urandom);
    frame("R9 restarted");

    // line noise, no strobe (R8, R10)
    for (int i = 0; i < 300; i++) drive(1'b0, 1'($urandom));
    chk(pulses == exp_pulses, "R10 no frame without strobe", 64'(pulses), 64'(exp_pulses));
    check_outputs("R8 hold");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule